// File: doc/BRIEF.md
# Big-Endian Program Image Loader

This block takes a program object image delivered one byte at a time and places it in a word-addressed memory. Bytes are paired into 16-bit words, with the earlier byte of each pair forming the upper half. The first word of an image is a header, not data: it gives the address at which the program is placed. Every word after it is written through a simple memory write port, starting at that address and moving up by one word per write.

The input uses a valid/ready handshake with an end-of-image flag on the final byte. When the image is complete and its last write has been taken by the memory port, the loader pulses a done flag. It also keeps the header address on an output, so that a processor core can begin fetching from the start of the program. The memory port can push back with a busy input. While the port is busy, the loader holds the pending write steady and stops taking bytes. After the done pulse the loader is ready for a fresh image, whose first two bytes again form a header.

Top module: `image_loader`

## Requirements
- R1: Each word is assembled big-endian: the first accepted byte of a pair becomes bits [15:8] of the word and the second becomes bits [7:0].
- R2: The first word of an image is never written to memory. It becomes the origin output, and the first data word is written at exactly that address.
- R3: Each later data word is written at the address one above the previous data word of the same image, in arrival order, with exactly one write per word.
- R4: The write address wraps from the top of the address space (0xFFFF at the default width) to 0x0000, and odd_error is not raised.
- R5: load_done is high for exactly one cycle per image. It rises only when no write is outstanding. With an idle memory port, an image ending on the second byte of a data word pulses done two cycles after the final byte is accepted. An image ending on a header byte or on a dangling byte pulses done one cycle after the final byte is accepted.
- R6: load_origin changes only when the header of an image completes, and it otherwise holds its value, including after done.
- R7: If the end flag comes with the first byte of a pair, that byte is not written and odd_error is set. odd_error stays set until the first byte of the next image is accepted, and that byte clears it.
- R8: A write issued while mem_busy is high stays on the port with unchanged address and data until a cycle with mem_busy low. in_ready is low in every such busy cycle.
- R9: in_ready is low from the cycle after the final byte is accepted until load_done has pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A byte is offered on in_data |
| in_data | input | 8 | Image byte |
| in_last | input | 1 | Marks the final byte of the image |
| in_ready | output | 1 | The loader takes the offered byte this cycle |
| mem_busy | input | 1 | The memory port cannot take a write this cycle |
| mem_we | output | 1 | Write request |
| mem_addr | output | ADDR_W | Word address of the write |
| mem_wdata | output | 16 | Word to write |
| load_done | output | 1 | One-cycle pulse when the image is fully placed |
| load_origin | output | ADDR_W | Address given by the latest completed header |
| odd_error | output | 1 | The latest image ended with an unpaired byte |

## Verification
On every cycle the assertions check four things. A stalled write keeps its address and data. load_done never lasts two cycles and never overlaps a write. The origin and the error flag move only on an accepted byte. What the assertions cannot see is the ordering across a whole image. That covers the byte-to-word packing, the header being left out of memory, the address sequence and its wrap, and the exact cycle of the done pulse. Directed scenarios check these against a write log built in the bench, along with the rule that a dangling byte is dropped and the error flag is cleared by the next image.

// File: rtl/image_loader.sv
module image_loader #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  output logic              in_ready,
  input  logic              mem_busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_wdata,
  output logic              load_done,
  output logic [ADDR_W-1:0] load_origin,
  output logic              odd_error
);

  typedef enum logic [1:0] {HDR_HI, HDR_LO, DAT_HI, DAT_LO} phase_t;

  phase_t            phase;
  logic [7:0]        upper;
  logic              wr_pend;
  logic [ADDR_W-1:0] wr_addr;
  logic [15:0]       wr_data;
  logic [ADDR_W-1:0] cursor;
  logic [ADDR_W-1:0] origin_q;
  logic              finishing;
  logic              err_q;

  logic        take;
  logic [15:0] word;

  assign in_ready    = !finishing && !(wr_pend && mem_busy);
  assign take        = in_valid && in_ready;
  assign word        = {upper, in_data};
  assign mem_we      = wr_pend;
  assign mem_addr    = wr_addr;
  assign mem_wdata   = wr_data;
  assign load_done   = finishing && !wr_pend;
  assign load_origin = origin_q;
  assign odd_error   = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= HDR_HI;
      upper     <= '0;
      wr_pend   <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      cursor    <= '0;
      origin_q  <= '0;
      finishing <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      if (wr_pend && !mem_busy) wr_pend <= 1'b0;
      if (load_done) finishing <= 1'b0;
      if (take) begin
        unique case (phase)
          HDR_HI: begin
            upper <= in_data;
            err_q <= in_last;
            if (in_last) finishing <= 1'b1;
            else         phase     <= HDR_LO;
          end
          HDR_LO: begin
            origin_q <= word[ADDR_W-1:0];
            cursor   <= word[ADDR_W-1:0];
            phase    <= in_last ? HDR_HI : DAT_HI;
            if (in_last) finishing <= 1'b1;
          end
          DAT_HI: begin
            upper <= in_data;
            if (in_last) begin
              err_q     <= 1'b1;
              finishing <= 1'b1;
              phase     <= HDR_HI;
            end else begin
              phase <= DAT_LO;
            end
          end
          DAT_LO: begin
            wr_pend <= 1'b1;
            wr_addr <= cursor;
            wr_data <= word;
            cursor  <= cursor + 1'b1;
            phase   <= in_last ? HDR_HI : DAT_HI;
            if (in_last) finishing <= 1'b1;
          end
          default: phase <= HDR_HI;
        endcase
      end
    end
  end

  AST_HOLD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we && mem_busy |=> mem_we && $stable(mem_addr) && $stable(mem_wdata)); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> !load_done); // R5

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |-> !mem_we); // R5

  AST_ORIGIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> $stable(load_origin)); // R6

  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> $stable(odd_error)); // R7

endmodule

// File: tb/sim_image_loader.sv
module sim_image_loader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_last = 1'b0;
  logic        in_ready;
  logic        mem_busy = 1'b0;
  logic        mem_we;
  logic [15:0] mem_addr;
  logic [15:0] mem_wdata;
  logic        load_done;
  logic [15:0] load_origin;
  logic        odd_error;

  int checks = 0;
  int errors = 0;

  logic [15:0] log_a [0:63];
  logic [15:0] log_d [0:63];
  int log_n = 0;
  int done_n = 0;

  always #5 clk = ~clk;

  image_loader #(.ADDR_W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_ready(in_ready), .mem_busy(mem_busy),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .load_done(load_done), .load_origin(load_origin), .odd_error(odd_error)
  );

  always @(posedge clk) begin
    if (rst_n && mem_we && !mem_busy && log_n < 64) begin
      log_a[log_n] <= mem_addr;
      log_d[log_n] <= mem_wdata;
      log_n <= log_n + 1;
    end
    if (rst_n && load_done) done_n <= done_n + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] d, input logic last);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    in_last  = last;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic send_word(input logic [15:0] w, input logic last);
    send_byte(w[15:8], 1'b0);
    send_byte(w[7:0], last);
  endtask

  task automatic settle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R9 reset ready", in_ready, 1);
    chk("R3 reset no write", mem_we, 0);
    chk("R5 reset done", load_done, 0);
    chk("R7 reset err", odd_error, 0);
    chk("R6 reset origin", load_origin, 0);
  endtask

  task automatic t_basic();
    int b = log_n;
    int d0 = done_n;
    send_word(16'h3000, 0);
    chk("R2 header not written", log_n - b, 0);
    send_word(16'hE002, 0);
    send_word(16'hF022, 0);
    send_word(16'hF025, 1);
    chk("R5 write pending no done", load_done, 0);
    chk("R3 final write issued", mem_we, 1);
    chk("R9 ready low after last", in_ready, 0);
    @(negedge clk);
    chk("R5 done two cycles after", load_done, 1);
    chk("R9 ready low during done", in_ready, 0);
    @(negedge clk);
    chk("R5 done one cycle", load_done, 0);
    chk("R9 ready back", in_ready, 1);
    chk("R5 done count", done_n - d0, 1);
    chk("R3 write count", log_n - b, 3);
    chk("R2 first at origin", log_a[b], 16'h3000);
    chk("R1 first word", log_d[b], 16'hE002);
    chk("R3 second addr", log_a[b+1], 16'h3001);
    chk("R1 second word", log_d[b+1], 16'hF022);
    chk("R3 third addr", log_a[b+2], 16'h3002);
    chk("R1 third word", log_d[b+2], 16'hF025);
    chk("R2 origin", load_origin, 16'h3000);
    chk("R7 no err", odd_error, 0);
  endtask

  task automatic t_wrap();
    int b = log_n;
    send_word(16'hFFFE, 0);
    send_word(16'h1111, 0);
    send_word(16'h2222, 0);
    send_word(16'h3333, 1);
    settle(3);
    chk("R4 count", log_n - b, 3);
    chk("R4 addr top-1", log_a[b], 16'hFFFE);
    chk("R4 addr top", log_a[b+1], 16'hFFFF);
    chk("R4 addr wrapped", log_a[b+2], 16'h0000);
    chk("R4 wrapped data", log_d[b+2], 16'h3333);
    chk("R4 no err", odd_error, 0);
  endtask

  task automatic t_odd();
    int b = log_n;
    int d0 = done_n;
    send_word(16'h0100, 0);
    send_word(16'hABCD, 0);
    send_byte(8'h77, 1);
    chk("R5 odd done next cycle", load_done, 1);
    chk("R7 err set", odd_error, 1);
    settle(3);
    chk("R7 dangling not written", log_n - b, 1);
    chk("R1 kept word", log_d[b], 16'hABCD);
    chk("R5 odd done count", done_n - d0, 1);
    chk("R6 origin held after done", load_origin, 16'h0100);
    chk("R7 err holds", odd_error, 1);
    send_byte(8'h02, 0);
    chk("R7 err cleared by new image", odd_error, 0);
    chk("R6 origin held mid header", load_origin, 16'h0100);
    send_byte(8'h00, 0);
    chk("R6 origin updated", load_origin, 16'h0200);
    send_word(16'h5A5A, 1);
    settle(3);
    chk("R2 second image addr", log_a[b+1], 16'h0200);
  endtask

  task automatic t_busy();
    int b = log_n;
    send_word(16'h0800, 0);
    send_byte(8'h12, 0);
    mem_busy = 1'b1;
    send_byte(8'h34, 0);
    for (int i = 0; i < 3; i++) begin
      chk("R8 write held", mem_we, 1);
      chk("R8 addr held", mem_addr, 16'h0800);
      chk("R8 data held", mem_wdata, 16'h1234);
      chk("R8 ready low", in_ready, 0);
      @(negedge clk);
    end
    chk("R8 not logged while busy", log_n - b, 0);
    mem_busy = 1'b0;
    send_word(16'h5678, 1);
    settle(3);
    chk("R8 one write per word", log_n - b, 2);
    chk("R8 next addr", log_a[b+1], 16'h0801);
  endtask

  task automatic t_header_only();
    int b = log_n;
    int d0 = done_n;
    send_word(16'h4000, 1);
    chk("R5 header-only done", load_done, 1);
    settle(2);
    chk("R2 header-only no write", log_n - b, 0);
    chk("R2 header-only origin", load_origin, 16'h4000);
    chk("R5 header-only count", done_n - d0, 1);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_wrap();
        t_odd();
        t_busy();
        t_header_only();
      end
      begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule